// File: doc/BRIEF.md
# Configurable sum-of-products logic array

This block is a small two-level logic array whose personality is loaded at run time. A first plane of product terms forms an AND over the data inputs. Each input can take part in a term in true form or complemented form, or stay out of it. A second plane ORs chosen terms into each output. The outputs are a purely combinational function of the data inputs and the stored personality. Configuration only changes the stored rows.

The OR plane is selected at elaboration. In the programmable variant (`FIXED_OR = 0`), every output has its own stored connection mask. Any term may feed any number of outputs, so one term can serve several functions. In the fixed variant (`FIXED_OR = 1`), output `o` is hard-wired to the group of `TERMS_PER_OUT` terms starting at term `o*TERMS_PER_OUT`. In that variant only the AND plane is programmable, and any unused term in a group stays at 0 by leaving it unprogrammed.

Rows are written one per cycle through an address, data and write-enable port. A combinational readback port returns the stored row at any address.

Top module: `sop_logic_array`

## Requirements
- R1: An AND-plane row holds two bits per input. Input `i` uses row bits `[2i+1:2i]`. The code 01 requires the input to be 1, 10 requires it to be 0, and 00 means the input does not take part. The code 11 makes the term never assert.
- R2: A product term whose row is all zero (every input absent) evaluates to 0 and asserts no output.
- R3: In the programmable variant, `data_out[o]` is the OR of every term `t` whose bit `t` is set in OR row `o`. A single term may drive several outputs at once.
- R4: In the fixed variant, `data_out[o]` is the OR of terms `o*TERMS_PER_OUT` to `o*TERMS_PER_OUT+TERMS_PER_OUT-1`. OR-plane writes are ignored, and OR readback of row `o` returns that fixed group mask.
- R5: Reset clears every AND row to absent and every programmable OR row to not connected. All outputs then read 0, and readback of those rows returns 0.
- R6: A write with `cfg_we` high is stored at the rising edge. `cfg_sel_or` = 0 selects the AND plane and 1 selects the OR plane. From then on, the outputs and the readback reflect the new row, and other rows are unchanged.
- R7: A write or read at an address beyond the selected plane has no effect. Such a read returns 0, and no existing row changes.
- R8: With a 4-input, 4-output fixed array of 4 terms per output, and inputs A..D on `data_in[3:0]`, the array realises the BCD code converter W = A + BD + BC, X = BC', Y = B + C, Z = A'B'C'D + BCD + AD' + B'CD'. W, X, Y and Z are on `data_out[3:0]`.
- R9: The outputs follow a change of `data_in` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write enable for one personality row |
| cfg_sel_or | input | 1 | Plane for the write: 0 selects the AND plane, 1 selects the OR plane |
| cfg_addr | input | ADDR_W | Term index (AND plane) or output index (OR plane) |
| cfg_wdata | input | CFG_W | Row data; the AND rows use the low 2*N_IN bits and the OR rows use the low N_TERM bits |
| rd_sel_or | input | 1 | Plane for readback |
| rd_addr | input | ADDR_W | Readback row address |
| rd_data | output | CFG_W | Stored row at `rd_addr`, zero-extended |
| data_in | input | N_IN | Logic inputs |
| data_out | output | N_OUT | Sum-of-products outputs |

## Verification
The corner cases the bench goes after are these:
- An all-absent term. A design that let it evaluate as an empty AND would drive 1 onto every output it reaches.
- The contradictory code 11. If it were mishandled, an output would assert when one of its literals matched.
- A single term shared by all four outputs. This shows whether reuse works, or whether a design quietly limits each term to one output.
- Out-of-range addresses. A design that wrapped or truncated them would corrupt a low-numbered row, and readback shows that.
- An OR-plane write to the fixed variant. A design that honoured it would break the code converter.

Random personalities, each swept over all sixteen input values, catch errors in the literal polarity and the term-to-output indexing.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    LIT_ABSENT = 2'b00,
    LIT_TRUE   = 2'b01,
    LIT_COMPL  = 2'b10,
    LIT_NEVER  = 2'b11
  } lit_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [2*N_IN-1:0]   wr_row,
  input  logic [N_IN-1:0]     data_in,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [2*N_IN-1:0]   rd_row,
  output logic [N_TERM-1:0]   term
);

  localparam int ROW_W = 2 * N_IN;
  localparam int IDX_W = idx_width(N_TERM);

  logic [ROW_W-1:0] row_q [N_TERM];
  logic [ROW_W-1:0] row_d [N_TERM];
  logic [N_TERM-1:0] hit;

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    assign hit[t] = wr_en && (wr_addr == ADDR_W'(t));

    always_comb begin
      row_d[t] = row_q[t];
      if (hit[t]) row_d[t] = wr_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[t] <= '0;
      else if (hit[t]) row_q[t] <= row_d[t];
    end

    always_comb begin
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        case (lit_e'(row_q[t][2*i +: 2]))
          LIT_TRUE:  if (!data_in[i]) ok = 1'b0;
          LIT_COMPL: if (data_in[i])  ok = 1'b0;
          LIT_NEVER: ok = 1'b0;
          default:   ok = ok;
        endcase
      end
      term[t] = ok && (|row_q[t]);
    end

    assert_empty_term_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (row_q[t] == '0) |-> !term[t]);

    assert_row_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[t] |=> (row_q[t] == $past(wr_row)));

    assert_row_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[t] |=> $stable(row_q[t]));

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assert_never_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q[t][2*i +: 2] == 2'b11) |-> !term[t]);
    end
  end

  always_comb begin
    rd_row = '0;
    if (int'(rd_addr) < N_TERM) rd_row = row_q[rd_addr[IDX_W-1:0]];
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_pkg::*;
#(
  parameter int N_TERM        = 16,
  parameter int N_OUT         = 4,
  parameter int ADDR_W        = 4,
  parameter bit FIXED_OR      = 1'b0,
  parameter int TERMS_PER_OUT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N_TERM-1:0] wr_mask,
  input  logic [N_TERM-1:0] term,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N_TERM-1:0] rd_mask,
  output logic [N_OUT-1:0]  data_out
);

  localparam int IDX_W = idx_width(N_OUT);

  logic [N_TERM-1:0] conn [N_OUT];

  if (FIXED_OR) begin : g_fixed
    wire unused_fixed = ^{clk, wr_en, wr_addr, wr_mask};

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      for (genvar t = 0; t < N_TERM; t++) begin : g_bit
        assign conn[o][t] = ((t / TERMS_PER_OUT) == o);
      end

      assert_fixed_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_out[o] |-> (|(term & conn[o])));
    end
  end else begin : g_prog
    logic [N_TERM-1:0] conn_q [N_OUT];
    logic [N_TERM-1:0] conn_d [N_OUT];
    logic [N_OUT-1:0]  hit;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      assign hit[o] = wr_en && (wr_addr == ADDR_W'(o));

      always_comb begin
        conn_d[o] = conn_q[o];
        if (hit[o]) conn_d[o] = wr_mask;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      conn_q[o] <= '0;
        else if (hit[o]) conn_q[o] <= conn_d[o];
      end

      assign conn[o] = conn_q[o];

      assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit[o] |=> (conn_q[o] == $past(wr_mask)));

      assert_out_needs_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_out[o] |-> (|(term & conn_q[o])));
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign data_out[o] = |(term & conn[o]);
  end

  always_comb begin
    rd_mask = '0;
    if (int'(rd_addr) < N_OUT) rd_mask = conn[rd_addr[IDX_W-1:0]];
  end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int N_IN          = 4,
  parameter int N_TERM        = 16,
  parameter int N_OUT         = 4,
  parameter bit FIXED_OR      = 1'b0,
  parameter int TERMS_PER_OUT = 4,
  parameter int ADDR_W        = idx_width(max_int(N_TERM, N_OUT)),
  parameter int CFG_W         = max_int(2 * N_IN, N_TERM)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel_or,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_sel_or,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CFG_W-1:0]  rd_data,
  input  logic [N_IN-1:0]   data_in,
  output logic [N_OUT-1:0]  data_out
);

  localparam int ROW_W = 2 * N_IN;

  logic              rst_n;
  logic [N_TERM-1:0] term;
  logic [ROW_W-1:0]  rd_row;
  logic [N_TERM-1:0] rd_mask;
  logic              and_we;
  logic              or_we;

  assign and_we = cfg_we && !cfg_sel_or;
  assign or_we  = cfg_we &&  cfg_sel_or;

  sop_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  sop_and_plane #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .ADDR_W (ADDR_W)
  ) u_and (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (and_we),
    .wr_addr (cfg_addr),
    .wr_row  (cfg_wdata[ROW_W-1:0]),
    .data_in (data_in),
    .rd_addr (rd_addr),
    .rd_row  (rd_row),
    .term    (term)
  );

  sop_or_plane #(
    .N_TERM        (N_TERM),
    .N_OUT         (N_OUT),
    .ADDR_W        (ADDR_W),
    .FIXED_OR      (FIXED_OR),
    .TERMS_PER_OUT (TERMS_PER_OUT)
  ) u_or (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (or_we),
    .wr_addr  (cfg_addr),
    .wr_mask  (cfg_wdata[N_TERM-1:0]),
    .term     (term),
    .rd_addr  (rd_addr),
    .rd_mask  (rd_mask),
    .data_out (data_out)
  );

  assign rd_data = rd_sel_or ? CFG_W'(rd_mask) : CFG_W'(rd_row);

  assert_reset_outputs_low_R5: assert property (@(posedge clk)
    $rose(rst_n) |-> (data_out == '0));

endmodule

// File: tb/sop_logic_array_tb.sv
module sop_logic_array_tb;

  logic        clk = 1'b0;
  logic        arst_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel_or = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        rd_sel_or = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [3:0]  data_in = '0;
  logic [7:0]  p_rd;
  logic [3:0]  p_out;
  logic [15:0] f_rd;
  logic [3:0]  f_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_row [8];
  logic [7:0] m_conn [4];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  sop_logic_array #(
    .N_IN(4), .N_TERM(8), .N_OUT(4), .FIXED_OR(1'b0), .TERMS_PER_OUT(4), .ADDR_W(4)
  ) u_dut (
    .clk(clk), .arst_n(arst_n), .cfg_we(cfg_we), .cfg_sel_or(cfg_sel_or),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata[7:0]), .rd_sel_or(rd_sel_or),
    .rd_addr(rd_addr), .rd_data(p_rd), .data_in(data_in), .data_out(p_out)
  );

  sop_logic_array #(
    .N_IN(4), .N_TERM(16), .N_OUT(4), .FIXED_OR(1'b1), .TERMS_PER_OUT(4), .ADDR_W(4)
  ) u_dut_fix (
    .clk(clk), .arst_n(arst_n), .cfg_we(cfg_we), .cfg_sel_or(cfg_sel_or),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_sel_or(rd_sel_or),
    .rd_addr(rd_addr), .rd_data(f_rd), .data_in(data_in), .data_out(f_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_or = sel; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_in(input logic [3:0] v);
    data_in = v;
    #1;
  endtask

  function automatic bit term_val(input logic [7:0] row, input logic [3:0] x);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (row[2*i +: 2] == 2'b01 && !x[i]) ok = 1'b0;
      if (row[2*i +: 2] == 2'b10 &&  x[i]) ok = 1'b0;
      if (row[2*i +: 2] == 2'b11)          ok = 1'b0;
    end
    return ok && (row != 8'h00);
  endfunction

  function automatic logic [3:0] model_out(input logic [3:0] x);
    logic [3:0] r;
    r = '0;
    for (int o = 0; o < 4; o++)
      for (int t = 0; t < 8; t++)
        if (m_conn[o][t] && term_val(m_row[t], x)) r[o] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] gray_ref(input logic [3:0] x);
    logic a, b, c, d;
    {a, b, c, d} = x;
    return {a | (b & d) | (b & c),
            b & !c,
            b | c,
            (!a & !b & !c & d) | (b & c & d) | (a & !d) | (!b & c & !d)};
  endfunction

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    return v ^ (v << 5);
  endfunction

  task automatic gray_sweep(input string req);
    for (int v = 0; v < 16; v++) begin
      set_in(4'(v));
      check(req, 16'(f_out), 16'(gray_ref(4'(v))));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_row[i] = '0;
    for (int i = 0; i < 4; i++) m_conn[i] = '0;
    #2 arst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: cleared rows, outputs low
    rd_sel_or = 1'b0; rd_addr = 4'd0; #1;
    check("R5 and row readback", 16'(p_rd), 16'h0);
    rd_sel_or = 1'b1; rd_addr = 4'd2; #1;
    check("R5 or row readback", 16'(p_rd), 16'h0);
    for (int v = 0; v < 16; v++) begin
      set_in(4'(v));
      check("R5 R2 outputs after reset", 16'(p_out), 16'h0);
    end

    // R4: fixed readback is the group mask
    for (int o = 0; o < 4; o++) begin
      rd_sel_or = 1'b1; rd_addr = 4'(o); #1;
      check("R4 fixed mask readback", f_rd, 16'h000F << (4*o));
    end

    // R6 and R7: write row 1, then out-of-range writes
    wr(1'b0, 4'd1, 16'h0066);
    rd_sel_or = 1'b0; rd_addr = 4'd1; #1;
    check("R6 and row written", 16'(p_rd), 16'h0066);
    wr(1'b0, 4'd9, 16'h00FF);
    rd_addr = 4'd9; #1;
    check("R7 out-of-range read", 16'(p_rd), 16'h0);
    rd_addr = 4'd1; #1;
    check("R7 row 1 untouched", 16'(p_rd), 16'h0066);
    wr(1'b1, 4'd5, 16'h00FF);
    rd_sel_or = 1'b1;
    for (int o = 0; o < 4; o++) begin
      rd_addr = 4'(o); #1;
      check("R7 or rows untouched", 16'(p_rd), 16'h0);
    end
    wr(1'b0, 4'd1, 16'h0000);

    // R3: one term A&B shared by all outputs; R2 before connecting
    wr(1'b0, 4'd0, 16'h0050);
    set_in(4'hC);
    check("R2 term unconnected", 16'(p_out), 16'h0);
    for (int o = 0; o < 4; o++) wr(1'b1, 4'(o), 16'h0001);
    for (int v = 0; v < 16; v++) begin
      set_in(4'(v));
      check("R3 shared term", 16'(p_out), (v[3] && v[2]) ? 16'hF : 16'h0);
    end
    // R1: code 11 on input D disables the term
    wr(1'b0, 4'd0, 16'h0053);
    for (int v = 0; v < 16; v++) begin
      set_in(4'(v));
      check("R1 never code", 16'(p_out), 16'h0);
    end
    // R9: data change mid-cycle, no edge between
    wr(1'b0, 4'd0, 16'h0050);
    @(posedge clk); #1;
    data_in = 4'h0; #1;
    check("R9 comb low", 16'(p_out), 16'h0);
    data_in = 4'hF; #1;
    check("R9 comb high", 16'(p_out), 16'hF);

    // R1 R3: random personalities, exhaustive input sweep
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < 8; t++) begin
        seed = rnd(seed);
        m_row[t] = seed[7:0];
        wr(1'b0, 4'(t), {8'h00, seed[7:0]});
      end
      for (int o = 0; o < 4; o++) begin
        seed = rnd(seed);
        m_conn[o] = seed[15:8];
        wr(1'b1, 4'(o), {8'h00, seed[15:8]});
      end
      for (int v = 0; v < 16; v++) begin
        set_in(4'(v));
        check("R1 R3 random personality", 16'(p_out), 16'(model_out(4'(v))));
      end
    end

    // R8: code converter on the fixed array
    for (int t = 0; t < 16; t++) wr(1'b0, 4'(t), 16'h0000);
    wr(1'b0, 4'd0,  16'h00A9);
    wr(1'b0, 4'd1,  16'h0015);
    wr(1'b0, 4'd2,  16'h0042);
    wr(1'b0, 4'd3,  16'h0026);
    wr(1'b0, 4'd4,  16'h0010);
    wr(1'b0, 4'd5,  16'h0004);
    wr(1'b0, 4'd8,  16'h0018);
    wr(1'b0, 4'd12, 16'h0040);
    wr(1'b0, 4'd13, 16'h0011);
    wr(1'b0, 4'd14, 16'h0014);
    gray_sweep("R8 code converter");

    // R4: OR writes ignored in the fixed variant
    wr(1'b1, 4'd0, 16'hFFFF);
    wr(1'b1, 4'd3, 16'h0000);
    rd_sel_or = 1'b1; rd_addr = 4'd0; #1;
    check("R4 or write ignored row0", f_rd, 16'h000F);
    rd_addr = 4'd3; #1;
    check("R4 or write ignored row3", f_rd, 16'hF000);
    gray_sweep("R4 outputs after ignored write");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule